// File: doc/BRIEF.md
# Unaligned Read Request Splitter

This block takes a read command (a byte start address and a byte length) and breaks it into bus read requests that a simple bus can carry. Every request carries an address aligned to the native data width, a beat count and one byte-enable bit per byte of the native word.

A starting part that does not begin on a word boundary becomes one single-beat request, with enables only for the bytes that belong to the command. An ending part that does not fill its word also becomes one single-beat request. The whole words in between go out as full-width bursts of up to `MAX_BEATS` beats. A run of exactly one whole word, or a command that is too short for any burst, is carried as single-beat requests. The command input and the request output each use a valid/ready handshake.

Top module: `burst_splitter`

## Requirements
- R1: `DATA_W` may be 32, 64 or 128. `req_be` has `DATA_W/8` bits. Bit i enables the byte at `req_addr + i`. Every request has `req_addr` aligned to `DATA_W/8` bytes and a nonzero `req_be`.
- R2: A command whose bytes all lie in one native word produces exactly one request. It has `req_beats` = 1, and its enables cover exactly the bytes from the start address up to start+length-1.
- R3: A command that does not start on a word boundary and runs past its first word begins with a single-beat request to that first word. Its enables are set from the start offset up to the top byte of the word.
- R4: The whole words after the head are requested in ascending address order as bursts of full enables (all ones). Each burst has at most `MAX_BEATS` (16) beats. Each request's address follows straight on from the previous request's address plus beats times `DATA_W/8`.
- R5: A group of whole words that ends with exactly one word, including a middle section of a single word, is issued as a request with `req_beats` = 1 and all enables set.
- R6: A command whose end (start+length) is not on a word boundary and that spans more than one word ends with a single-beat request to its last word. Its enables are set for the low (end mod `DATA_W/8`) bytes only.
- R7: `cmd_ready` is high only while no request is pending. Commands offered while requests are pending stay waiting. The block is idle again in the cycle after the handshake of its last request.
- R8: A command of zero length is accepted at once and produces no request.
- R9: While `req_valid` is high and `req_ready` is low, the request holds and its address, beat count and enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_addr | input | ADDR_W | Byte start address |
| cmd_len | input | LEN_W | Length in bytes |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus takes the request |
| req_addr | output | ADDR_W | Word-aligned request address |
| req_beats | output | $clog2(MAX_BEATS+1) | Beats in the request, 1 for single |
| req_be | output | DATA_W/8 | Byte enables, bit i for byte req_addr+i |

## Verification
The hardest case to reach is a new command waiting at the input while the previous one still has requests pending. It must not be taken early, and it must be taken in the first idle cycle. The bench reaches this case by keeping a second command valid for the whole time the first command's requests are drained with back-pressure. It then checks that the two request streams stay separate. Burst-length limits are reached with aligned commands of 17 and 40 words.

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BEATS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [ADDR_W-1:0]              cmd_addr,
  input  logic [LEN_W-1:0]               cmd_len,
  output logic                           req_valid,
  input  logic                           req_ready,
  output logic [ADDR_W-1:0]              req_addr,
  output logic [$clog2(MAX_BEATS+1)-1:0] req_beats,
  output logic [DATA_W/8-1:0]            req_be
);
  localparam int NB  = DATA_W / 8;
  localparam int OFS = $clog2(NB);
  localparam int WA  = ADDR_W - OFS;
  localparam int BW  = $clog2(MAX_BEATS + 1);
  localparam logic [NB-1:0] ONES = '1;

  typedef enum logic [1:0] {IDLE, HEAD, MID, TAIL} phase_t;

  phase_t          phase;
  logic [WA-1:0]   word;
  logic [LEN_W-1:0] mid_left;
  logic            tail_pend;
  logic [NB-1:0]   head_be, tail_be;

  // command decode
  logic [ADDR_W-1:0] c_end, c_lastb;
  logic [WA-1:0]     c_first, c_last, c_mid;
  logic [OFS-1:0]    c_hoff, c_toff;
  logic              c_hpart, c_tpart, c_one;
  logic [NB-1:0]     c_hmask, c_tmask;

  assign c_end   = cmd_addr + ADDR_W'(cmd_len);
  assign c_lastb = c_end - 1'b1;
  assign c_first = cmd_addr[ADDR_W-1:OFS];
  assign c_last  = c_lastb[ADDR_W-1:OFS];
  assign c_hoff  = cmd_addr[OFS-1:0];
  assign c_toff  = c_end[OFS-1:0];
  assign c_hpart = c_hoff != '0;
  assign c_tpart = c_toff != '0;
  assign c_one   = c_first == c_last;
  assign c_hmask = ONES << c_hoff;
  assign c_tmask = c_tpart ? ~(ONES << c_toff) : ONES;
  assign c_mid   = c_last - c_first + WA'(1) - WA'(c_hpart) - WA'(c_tpart);

  // middle chunking
  logic [LEN_W-1:0] mid_chunk;
  assign mid_chunk = (mid_left > LEN_W'(MAX_BEATS)) ? LEN_W'(MAX_BEATS) : mid_left;

  assign cmd_ready = phase == IDLE;
  assign req_valid = phase != IDLE;
  assign req_addr  = {word, {OFS{1'b0}}};
  assign req_beats = (phase == MID) ? BW'(mid_chunk) : BW'(1);
  assign req_be    = (phase == HEAD) ? head_be : (phase == TAIL) ? tail_be : ONES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= IDLE;
      word      <= '0;
      mid_left  <= '0;
      tail_pend <= 1'b0;
      head_be   <= '0;
      tail_be   <= '0;
    end else begin
      case (phase)
        IDLE: if (cmd_valid && cmd_len != '0) begin
          word    <= c_first;
          tail_be <= c_tmask;
          if (c_one) begin
            head_be   <= c_hmask & c_tmask;
            mid_left  <= '0;
            tail_pend <= 1'b0;
            phase     <= HEAD;
          end else begin
            head_be   <= c_hmask;
            mid_left  <= LEN_W'(c_mid);
            tail_pend <= c_tpart;
            phase     <= c_hpart ? HEAD : MID;
          end
        end
        HEAD: if (req_ready) begin
          word <= word + WA'(1);
          if (mid_left != '0)  phase <= MID;
          else if (tail_pend)  phase <= TAIL;
          else                 phase <= IDLE;
        end
        MID: if (req_ready) begin
          word     <= word + WA'(mid_chunk);
          mid_left <= mid_left - mid_chunk;
          if (mid_left == mid_chunk) phase <= tail_pend ? TAIL : IDLE;
        end
        TAIL: if (req_ready) phase <= IDLE;
        default: phase <= IDLE;
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_beats) && $stable(req_be));

  p_beats_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_beats >= BW'(1) && req_beats <= BW'(MAX_BEATS));

  p_burst_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_beats > BW'(1) |-> req_be == ONES);

  p_be_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_be != '0);

  p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid ||
      req_addr == $past(req_addr) + ($past(ADDR_W'(req_beats)) << OFS));

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_len == '0 |=> !req_valid && cmd_ready);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_len != '0 |=> req_valid && !cmd_ready);
endmodule

// File: tb/test_burst_splitter.sv
module test_burst_splitter;
  localparam int DATA_W = 32, ADDR_W = 32, LEN_W = 16, MAXB = 16;
  localparam int NB = DATA_W / 8;
  localparam int BW = $clog2(MAXB + 1);

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic req_valid, req_ready = 0;
  logic [ADDR_W-1:0] req_addr;
  logic [BW-1:0]     req_beats;
  logic [NB-1:0]     req_be;

  always #4 clk = ~clk;

  burst_splitter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BEATS(MAXB)) i_burst_splitter (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_len,
    .req_valid, .req_ready, .req_addr, .req_beats, .req_be);

  int checks = 0, failures = 0, cyc = 0;
  int exp_addr[128], exp_beats[128], exp_be[128], exp_n;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int a, int b, int m);
    exp_addr[exp_n] = a; exp_beats[exp_n] = b; exp_be[exp_n] = m; exp_n++;
  endtask

  // independent model: per-word masks, full words grouped in runs of up to MAXB
  task automatic build(int addr, int len);
    int rs = 0, rl = 0;
    exp_n = 0;
    if (len == 0) return;
    for (int w = addr / NB; w <= (addr + len - 1) / NB; w++) begin
      int m = 0;
      for (int b = 0; b < NB; b++)
        if (w*NB + b >= addr && w*NB + b < addr + len) m |= (1 << b);
      if (m == (1 << NB) - 1) begin
        if (rl == 0) rs = w;
        rl++;
        if (rl == MAXB) begin push(rs*NB, rl, m); rl = 0; end
      end else begin
        if (rl != 0) begin push(rs*NB, rl, (1 << NB) - 1); rl = 0; end
        push(w*NB, 1, m);
      end
    end
    if (rl != 0) push(rs*NB, rl, (1 << NB) - 1);
  endtask

  task automatic send(int addr, int len);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = addr; cmd_len = len;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic collect(string req, int stall);
    int idx = 0, guard = 0;
    bit held = 0;
    logic [ADDR_W-1:0] pa; logic [BW-1:0] pb; logic [NB-1:0] pm;
    while (idx < exp_n && guard < 3000) begin
      if (guard != 0) @(negedge clk);
      guard++;
      req_ready = (stall != 0) ? ((guard % stall) == 0) : 1'b1;
      if (held) begin
        check(req_valid && req_addr == pa && req_beats == pb && req_be == pm, "R9", "held request",
              {req_addr, req_beats, req_be}, {pa, pb, pm});
      end
      held = 0;
      if (req_valid) begin
        if (cmd_ready) check(0, "R7", "cmd_ready while busy", 1, 0);
        if (req_ready) begin
          check(req_addr == exp_addr[idx], req, "req_addr", req_addr, exp_addr[idx]);
          check(req_beats == exp_beats[idx], req, "req_beats", req_beats, exp_beats[idx]);
          check(req_be == exp_be[idx], req, "req_be", req_be, exp_be[idx]);
          idx++;
        end else begin
          held = 1; pa = req_addr; pb = req_beats; pm = req_be;
        end
      end
      @(posedge clk);
    end
    @(negedge clk);
    req_ready = 0;
    check(idx == exp_n, req, "request count", idx, exp_n);
    check(!req_valid && cmd_ready, "R7", "idle after last request", {req_valid, cmd_ready}, 2'b01);
  endtask

  task automatic run(int addr, int len, string req, int stall);
    build(addr, len);
    send(addr, len);
    collect(req, stall);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!req_valid && cmd_ready, "R7", "reset state", {req_valid, cmd_ready}, 2'b01);
  endtask

  task automatic t_one_word;      run('h21, 2, "R2", 0); run('h40, 3, "R2", 2); endtask
  task automatic t_head_tail;     run('h1E, 4, "R3 R6", 3); endtask
  task automatic t_mid_single;    run('h42, 8, "R5", 0); endtask
  task automatic t_long_aligned;  run('h100, 160, "R4", 0); endtask
  task automatic t_seventeen;     run('h200, 68, "R4 R5", 2); endtask
  task automatic t_full_split;    run('h303, 70, "R1 R3 R4 R6", 3); endtask
  task automatic t_aligned_tail;  run('h400, 10, "R6", 0); endtask

  task automatic t_zero_len;
    send('h55, 0);
    repeat (3) @(negedge clk);
    check(!req_valid && cmd_ready, "R8", "zero length gives no request", {req_valid, cmd_ready}, 2'b01);
  endtask

  task automatic t_busy;
    build('h81, 40);
    send('h81, 40);
    cmd_valid = 1; cmd_addr = 'h502; cmd_len = 5;
    collect("R7", 2);
    @(negedge clk);
    cmd_valid = 0;
    build('h502, 5);
    collect("R7", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_one_word();
    t_head_tail();
    t_mid_single();
    t_long_aligned();
    t_seventeen();
    t_full_split();
    t_aligned_tail();
    t_zero_len();
    t_busy();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule